// File: doc/BRIEF.md
# Three-Group Interrupt Status Controller

This block gathers interrupt events from peripherals into three 8-bit status groups. Two groups, A and B, feed a shared normal interrupt line. The third group feeds a separate fast interrupt line. Each group has a status byte and a mask byte. The request byte is the status ANDed with the mask. Software reads the status, request and mask bytes over a small byte-wide register port, writes the masks, and acknowledges events through clear commands.

Group A holds sticky event flags: timer expiries, vertical flyback, and a power-on flag set at reset. Software clears these with a write-to-clear command that is masked to bits 2 to 6. Group B mixes level-following sources with two serial flags, receive-full and transmit-empty. These two flags are cleared as a side effect of reading or writing the serial data port. The fast group follows level inputs. Bit 7 of group A and bit 7 of the fast group are always set, so software can enable an interrupt that cannot be silenced at its source.

Top module: `intc_tri_group`

## Requirements
- R1: After reset, the group A status reads 0x90 (bit 7 always set, bit 4 power-on flag). The group B status reads 0x00 and the fast group status reads 0x80.
- R2: After reset, all three masks read 0x00 and both irq_o and fiq_o are low.
- R3: Offsets 0x14, 0x24 and 0x34 read the request (status AND mask) of groups A, B and fast. Offsets 0x10/0x20/0x30 read the status and 0x18/0x28/0x38 read the mask. A write to 0x18/0x28/0x38 loads that mask.
- R4: irq_o is registered. It goes high one clock after the request of group A or group B becomes non-zero, and it goes low one clock after both requests become zero.
- R5: A write to 0x14 clears the group A status bits given by (write data AND 0x7C). Bits 0, 1 and 7 are never changed by this write.
- R6: Pulse input a_set[n] sets group A status bit n (timer 0 on bit 5, timer 1 on bit 6, flyback on bit 3). The bit stays set until it is cleared. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: Group B bits 5..0 follow b_lvl[5..0] with one register stage. Bit 1 is the sound-buffer level.
- R8: b_rx_set sets group B bit 7 and b_tx_set sets group B bit 6. A read of offset 0x04 clears bit 7 and returns ser_rx_data. A write to offset 0x04 clears bit 6.
- R9: Fast group bits 6..0 follow fiq_lvl with one register stage. fiq_o is registered and is high one clock after the fast group request is non-zero, independently of irq_o.
- R10: A read from any offset that is not mapped returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ser_rx_data | input | 8 | Received serial byte, returned at offset 0x04 |
| a_set | input | 7 | Group A set pulses, bit n sets status bit n |
| b_lvl | input | 6 | Group B level sources for status bits 5..0 |
| b_rx_set | input | 1 | Receive-full set pulse (group B bit 7) |
| b_tx_set | input | 1 | Transmit-empty set pulse (group B bit 6) |
| fiq_lvl | input | 7 | Fast group level sources for status bits 6..0 |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The hardest case to create from the ports is a set pulse and a write-to-clear that land on the same status bit in the same clock. If they miss by one cycle, the test shows only ordinary set-then-clear behaviour. The bench therefore drives a_set and the clear write in one shared low clock phase, so both are sampled by the same edge. It then reads the status back to confirm the bit survived. The one-cycle lag of irq_o is checked by sampling it on the clock right after a set pulse, where it must still be low, and again on the next clock.

// File: rtl/intc_tri_group.sv
module intc_tri_group #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [7:0]    ser_rx_data,
  input  logic [6:0]    a_set,
  input  logic [5:0]    b_lvl,
  input  logic          b_rx_set,
  input  logic          b_tx_set,
  input  logic [6:0]    fiq_lvl,
  output logic          irq_o,
  output logic          fiq_o
);

  localparam logic [AW-1:0] OFS_PORT  = AW'(7'h04);
  localparam logic [AW-1:0] OFS_A_ST  = AW'(7'h10);
  localparam logic [AW-1:0] OFS_A_RQ  = AW'(7'h14);
  localparam logic [AW-1:0] OFS_A_MK  = AW'(7'h18);
  localparam logic [AW-1:0] OFS_B_ST  = AW'(7'h20);
  localparam logic [AW-1:0] OFS_B_RQ  = AW'(7'h24);
  localparam logic [AW-1:0] OFS_B_MK  = AW'(7'h28);
  localparam logic [AW-1:0] OFS_F_ST  = AW'(7'h30);
  localparam logic [AW-1:0] OFS_F_RQ  = AW'(7'h34);
  localparam logic [AW-1:0] OFS_F_MK  = AW'(7'h38);
  localparam logic [7:0]    A_CLR_MSK = 8'h7C;
  localparam logic [7:0]    A_RST     = 8'h90;
  localparam logic [7:0]    F_RST     = 8'h80;

  logic [7:0] st_a, st_b, st_f;
  logic [7:0] mk_a, mk_b, mk_f;
  logic [7:0] rq_a, rq_b, rq_f;

  logic wr_acc, rd_acc;
  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  logic clr_a_hit, port_rd, port_wr;
  assign clr_a_hit = wr_acc && (bus_addr == OFS_A_RQ);
  assign port_rd   = rd_acc && (bus_addr == OFS_PORT);
  assign port_wr   = wr_acc && (bus_addr == OFS_PORT);

  logic [7:0] clr_a;
  assign clr_a = clr_a_hit ? (bus_wdata & A_CLR_MSK) : 8'h00;

  assign rq_a = st_a & mk_a;
  assign rq_b = st_b & mk_b;
  assign rq_f = st_f & mk_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_a <= A_RST;
      st_b <= 8'h00;
      st_f <= F_RST;
    end else begin
      st_a <= (st_a & ~clr_a) | {1'b1, a_set};
      st_b <= {b_rx_set | (st_b[7] & ~port_rd),
               b_tx_set | (st_b[6] & ~port_wr),
               b_lvl};
      st_f <= {1'b1, fiq_lvl};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mk_a <= 8'h00;
      mk_b <= 8'h00;
      mk_f <= 8'h00;
    end else if (wr_acc) begin
      if (bus_addr == OFS_A_MK) mk_a <= bus_wdata;
      if (bus_addr == OFS_B_MK) mk_b <= bus_wdata;
      if (bus_addr == OFS_F_MK) mk_f <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= (|rq_a) | (|rq_b);
      fiq_o <= |rq_f;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_PORT: bus_rdata = ser_rx_data;
      OFS_A_ST: bus_rdata = st_a;
      OFS_A_RQ: bus_rdata = rq_a;
      OFS_A_MK: bus_rdata = mk_a;
      OFS_B_ST: bus_rdata = st_b;
      OFS_B_RQ: bus_rdata = rq_b;
      OFS_B_MK: bus_rdata = mk_b;
      OFS_F_ST: bus_rdata = st_f;
      OFS_F_RQ: bus_rdata = rq_f;
      OFS_F_MK: bus_rdata = mk_f;
      default:  bus_rdata = 8'hFF;
    endcase
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rq_a) || (|rq_b)) |=> irq_o);  // R4
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|rq_a) && !(|rq_b)) |=> !irq_o);  // R4
  AST_FIQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|rq_f) |=> fiq_o);  // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_set[5] && clr_a_hit && bus_wdata[5]) |=> st_a[5]);  // R6
  AST_CLR_SPARES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a_hit && a_set[1:0] == 2'b00) |=> (st_a[1:0] == $past(st_a[1:0])));  // R5
  AST_SND_HI: assert property (@(posedge clk) disable iff (!rst_n)
    b_lvl[1] |=> st_b[1]);  // R7
  AST_SND_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !b_lvl[1] |=> !st_b[1]);  // R7
  AST_RX_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && !b_rx_set) |=> !st_b[7]);  // R8
  AST_TX_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !b_tx_set) |=> !st_b[6]);  // R8

endmodule

// File: tb/tb_intc_tri_group.sv
module tb_intc_tri_group;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] ser_rx_data = 8'h5A;
  logic [6:0] a_set = '0;
  logic [5:0] b_lvl = '0;
  logic       b_rx_set = 1'b0, b_tx_set = 1'b0;
  logic [6:0] fiq_lvl = '0;
  logic       irq_o, fiq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intc_tri_group dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_rx_data(ser_rx_data), .a_set(a_set), .b_lvl(b_lvl),
    .b_rx_set(b_rx_set), .b_tx_set(b_tx_set), .fiq_lvl(fiq_lvl),
    .irq_o(irq_o), .fiq_o(fiq_o));

  // mask[22:15], set pulses[14:8], expected request[7:0]
  localparam logic [22:0] VEC [5] = '{
    {8'h80, 7'h00, 8'h80},
    {8'h20, 7'h20, 8'h20},
    {8'h40, 7'h60, 8'h40},
    {8'h08, 7'h08, 8'h08},
    {8'h10, 7'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse_a(input logic [6:0] v);
    @(negedge clk); a_set = v;
    @(negedge clk); a_set = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R2 irq_o at reset", {7'd0, irq_o}, 8'h00);
    chk("R2 fiq_o at reset", {7'd0, fiq_o}, 8'h00);
    rd(7'h10, r); chk("R1 status A reset", r, 8'h90);
    rd(7'h20, r); chk("R1 status B reset", r, 8'h00);
    rd(7'h30, r); chk("R1 status F reset", r, 8'h80);
    rd(7'h18, r); chk("R2 mask A reset", r, 8'h00);
    rd(7'h28, r); chk("R2 mask B reset", r, 8'h00);
    rd(7'h38, r); chk("R2 mask F reset", r, 8'h00);

    wr(7'h14, 8'hFF);
    rd(7'h10, r); chk("R5 clear POR keeps bit7", r, 8'h80);

    for (int i = 0; i < 5; i++) begin
      wr(7'h18, VEC[i][22:15]);
      rd(7'h18, r); chk("R3 mask A readback", r, VEC[i][22:15]);
      pulse_a(VEC[i][14:8]);
      rd(7'h14, r); chk("R3 R6 request A", r, VEC[i][7:0]);
      chk("R4 irq level", {7'd0, irq_o}, {7'd0, |VEC[i][7:0]});
      wr(7'h14, 8'h7C);
      wr(7'h18, 8'h00);
    end

    pulse_a(7'h03);
    wr(7'h14, 8'hFF);
    rd(7'h10, r); chk("R5 bits 0,1 survive clear", r, 8'h83);

    @(negedge clk);
    a_set = 7'h20; bus_sel = 1; bus_wr = 1; bus_addr = 7'h14; bus_wdata = 8'h20;
    @(negedge clk);
    a_set = '0; bus_sel = 0; bus_wr = 0;
    rd(7'h10, r); chk("R6 set beats clear", r, 8'hA3);
    wr(7'h14, 8'h20);
    rd(7'h10, r); chk("R5 R6 later clear works", r, 8'h83);

    @(negedge clk); b_lvl = 6'h02;
    rd(7'h20, r); chk("R7 sound level high", r, 8'h02);
    @(negedge clk); b_lvl = 6'h00;
    rd(7'h20, r); chk("R7 sound level low", r, 8'h00);

    @(negedge clk); b_rx_set = 1;
    @(negedge clk); b_rx_set = 0;
    rd(7'h20, r); chk("R8 rx full set", r, 8'h80);
    rd(7'h04, r); chk("R8 port read data", r, 8'h5A);
    rd(7'h20, r); chk("R8 rx cleared by read", r, 8'h00);
    @(negedge clk); b_tx_set = 1;
    @(negedge clk); b_tx_set = 0;
    rd(7'h20, r); chk("R8 tx empty set", r, 8'h40);
    wr(7'h04, 8'h33);
    rd(7'h20, r); chk("R8 tx cleared by write", r, 8'h00);

    wr(7'h28, 8'h80);
    @(negedge clk); b_rx_set = 1;
    @(negedge clk); b_rx_set = 0;
    chk("R4 irq lags one clock", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    chk("R4 irq high after lag", {7'd0, irq_o}, 8'h01);
    rd(7'h24, r); chk("R3 request B", r, 8'h80);
    rd(7'h04, r);
    @(negedge clk);
    chk("R4 irq low after ack", {7'd0, irq_o}, 8'h00);
    wr(7'h28, 8'h00);

    @(negedge clk); fiq_lvl = 7'h01;
    wr(7'h38, 8'h01);
    rd(7'h34, r); chk("R9 request F", r, 8'h01);
    chk("R9 fiq high", {7'd0, fiq_o}, 8'h01);
    chk("R9 irq unaffected", {7'd0, irq_o}, 8'h00);
    @(negedge clk); fiq_lvl = 7'h00;
    wr(7'h38, 8'h80);
    @(negedge clk);
    chk("R9 fiq from always-set bit", {7'd0, fiq_o}, 8'h01);
    wr(7'h38, 8'h00);
    @(negedge clk);
    chk("R9 fiq low when masked", {7'd0, fiq_o}, 8'h00);

    rd(7'h7C, r); chk("R10 unmapped read", r, 8'hFF);
    rd(7'h00, r); chk("R10 unmapped read 0", r, 8'hFF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule